// File: doc/BRIEF.md
# Receive Interrupt Threshold Unit

This unit decides when a receive path should interrupt its host. It keeps three running figures for the receive queue: how many frames are waiting, how many bytes those frames hold, and how many microsecond ticks have passed since the queue last went from empty to holding a frame. The queue logic reports each frame it stores and each frame it releases, together with that frame's length. A free-running 1 µs strobe advances the wait timer.

Each figure is compared with its own programmable limit, and each comparison has its own enable and its own status flag. Frames trigger when the count reaches the limit. Bytes and wait time trigger only when they go past their limits. Any active trigger sets one shared receive-interrupt status bit. That bit stays set until the host writes 1 to clear it. The interrupt pin shows that bit only while the interrupt enable is on. The register decode and the frame storage sit outside this unit.

Top module: `rx_irq_coalescer`

## Requirements
- R1: `frame_level` goes up by one for a stored frame and down by one for a released frame. A store and a release in the same cycle leave it unchanged. A release while it is 0 is ignored. It holds at 255 instead of wrapping. The new value is visible one clock after the event.
- R2: `byte_level` adds `enq_len` for a stored frame and subtracts `deq_len` for an accepted release. A result below 0 is clamped to 0, and the value saturates at 65535. It is visible one clock after the event.
- R3: `frame_hit` is 1 one clock after `frame_en` is 1 and `frame_level >= frame_thr`.
- R4: `byte_hit` is 1 one clock after `byte_en` is 1 and `byte_level > byte_thr`. Equality does not trigger.
- R5: `wait_level` is 0 while the queue is empty and returns to 0 in the cycle the queue empties. While frames are waiting, it gains one per `us_tick` and saturates. `time_hit` is 1 one clock after `time_en` is 1 and `wait_level > time_thr`.
- R6: A trigger whose enable is 0 keeps its status flag at 0 and never sets `irq_stat`, whatever its level and limit.
- R7: `irq_stat` becomes 1 one clock after any of `frame_hit`, `byte_hit` or `time_hit` is 1. It then stays 1 until it is cleared.
- R8: A cycle with `irq_clr` = 1 clears `irq_stat`. If any trigger flag is 1 in that same cycle, `irq_stat` stays 1.
- R9: `irq_out` equals `irq_stat` while `irq_en` is 1 and is 0 while `irq_en` is 0. It follows `irq_en` in the same cycle.
- R10: After a synchronous reset (`rst_n` = 0 at a clock edge), all levels, trigger flags, `irq_stat` and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | A frame was stored in the queue this cycle |
| enq_len | input | 11 | Byte length of the stored frame |
| deq_valid | input | 1 | A frame was released from the queue this cycle |
| deq_len | input | 11 | Byte length of the released frame |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| frame_thr | input | 8 | Frame-count limit |
| byte_thr | input | 16 | Byte-count limit |
| time_thr | input | 16 | Wait-time limit in microseconds |
| frame_en | input | 1 | Enables the frame-count trigger |
| byte_en | input | 1 | Enables the byte-count trigger |
| time_en | input | 1 | Enables the wait-time trigger |
| irq_en | input | 1 | Enables the interrupt pin |
| irq_clr | input | 1 | Write-1-to-clear strobe for `irq_stat` |
| frame_level | output | 8 | Frames currently queued |
| byte_level | output | 16 | Bytes currently queued |
| wait_level | output | 16 | Microseconds since the queue became non-empty |
| frame_hit | output | 1 | Frame-count trigger status |
| byte_hit | output | 1 | Byte-count trigger status |
| time_hit | output | 1 | Wait-time trigger status |
| irq_stat | output | 1 | Sticky receive-interrupt status |
| irq_out | output | 1 | Interrupt pin |

## Verification
The tally is driven with a table of mixed patterns: single stores, a store and a release in the same cycle, a release longer than the bytes held, and a release on an empty queue. This separates the net-zero case from the clamping and from the ignored release. Each trigger is then brought to one step below its limit, exactly to its limit, and one step past it. That shows the frame trigger firing on equality and the byte and time triggers firing only past the limit. Clearing is tried once while a trigger is still active and once after it has dropped, which separates a clear that is overridden by the trigger from one that takes effect. A long run of stores and releases checks that the frame count saturates and that the wait timer restarts from zero.

// File: rtl/rx_irq_pkg.sv
// Package rx_irq_pkg
// Purpose: types shared by the receive interrupt threshold unit.
// Assumes: nothing beyond IEEE 1800-2017.
package rx_irq_pkg;

    // Position of each trigger in the combined trigger vector
    typedef enum int unsigned {
        TRIG_FRAME = 0,
        TRIG_BYTE  = 1,
        TRIG_TIME  = 2
    } trig_idx_e;

    localparam int NUM_TRIG = 3;

endpackage

// File: rtl/rx_queue_tally.sv
// Module rx_queue_tally
// Purpose: keeps the number of queued frames and queued bytes, from the
//          store and release events reported by the queue logic.
// Assumes: at most one store and one release per cycle. A release while
//          the frame count is zero is ignored. Both counts saturate, and
//          the byte count clamps at zero.
module rx_queue_tally #(
    parameter int FRAME_W = 8,
    parameter int BYTE_W  = 16,
    parameter int LEN_W   = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    input  logic [LEN_W-1:0]   enq_len,
    input  logic               deq_valid,
    input  logic [LEN_W-1:0]   deq_len,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic [BYTE_W-1:0]  byte_cnt,
    output logic               busy_nxt
);

    localparam int                 SUM_W     = BYTE_W + 1;
    localparam logic [FRAME_W-1:0] FRAME_MAX = {FRAME_W{1'b1}};
    localparam logic [SUM_W-1:0]   BYTE_MAX  = {1'b0, {BYTE_W{1'b1}}};

    logic               deq_ok;
    logic [FRAME_W-1:0] frame_nxt;
    logic [SUM_W-1:0]   byte_add;
    logic [SUM_W-1:0]   byte_sub;
    logic [SUM_W-1:0]   byte_mid;
    logic [BYTE_W-1:0]  byte_nxt;

    // A release counts only when a frame is actually queued
    assign deq_ok = deq_valid && (frame_cnt != '0);

    // Next frame count: up, down or hold, saturating at the top
    always_comb begin
        frame_nxt = frame_cnt;
        case ({enq_valid, deq_ok})
            2'b10:   frame_nxt = (frame_cnt == FRAME_MAX) ? frame_cnt : frame_cnt + 1'b1;
            2'b01:   frame_nxt = frame_cnt - 1'b1;
            default: frame_nxt = frame_cnt;
        endcase
    end

    // Next byte count: add the stored length, subtract the released one, clamp
    always_comb begin
        byte_add = {1'b0, byte_cnt} + (enq_valid ? {{(SUM_W-LEN_W){1'b0}}, enq_len} : '0);
        byte_sub = deq_ok ? {{(SUM_W-LEN_W){1'b0}}, deq_len} : '0;
        byte_mid = (byte_add < byte_sub) ? '0 : (byte_add - byte_sub);
        byte_nxt = (byte_mid > BYTE_MAX) ? BYTE_MAX[BYTE_W-1:0] : byte_mid[BYTE_W-1:0];
    end

    // Tells the wait timer whether the queue will hold frames after this edge
    assign busy_nxt = (frame_nxt != '0);

    // Count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            byte_cnt  <= '0;
        end else begin
            frame_cnt <= frame_nxt;
            byte_cnt  <= byte_nxt;
        end
    end

    // A release on an empty queue leaves the count at zero
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !enq_valid && frame_cnt == '0) |=> (frame_cnt == '0));

    // A lone store below the top adds exactly one frame
    assert_store_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !deq_valid && frame_cnt != FRAME_MAX) |=> (frame_cnt == $past(frame_cnt) + 1'b1));

    // A store with no release never lowers the byte count
    assert_bytes_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !deq_valid) |=> (byte_cnt >= $past(byte_cnt)));

endmodule

// File: rtl/rx_wait_timer.sv
// Module rx_wait_timer
// Purpose: measures in microsecond ticks how long the receive queue has
//          held frames without becoming empty.
// Assumes: busy_nxt gives the queue state after the current edge, and
//          busy_now gives the state before it. A tick only counts while
//          frames were already waiting.
module rx_wait_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              busy_now,
    input  logic              busy_nxt,
    output logic [TIME_W-1:0] wait_cnt
);

    localparam logic [TIME_W-1:0] WAIT_MAX = {TIME_W{1'b1}};

    // Clear on an empty queue, step on a tick while busy, hold at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (!busy_nxt) begin
            wait_cnt <= '0;
        end else if (us_tick && busy_now && wait_cnt != WAIT_MAX) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // Without a tick, the timer of a busy queue does not move
    assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_nxt && !us_tick) |=> $stable(wait_cnt));

    // Once the queue is empty, the timer reads zero
    assert_zero_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_nxt) |=> (wait_cnt == '0));

endmodule

// File: rtl/rx_thresh_cmp.sv
// Module rx_thresh_cmp
// Purpose: compares a queue figure against its limit and registers the
//          result as a level status flag.
// Assumes: STRICT = 1 fires when the level is above the limit. STRICT = 0
//          also fires when the level equals the limit. The flag is 0
//          while the enable is off.
module rx_thresh_cmp #(
    parameter int W      = 16,
    parameter bit STRICT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] level,
    input  logic [W-1:0] thr,
    output logic         hit
);

    logic over;

    // Pick the comparison rule for this trigger
    generate
        if (STRICT) begin : g_strict
            assign over = (level > thr);
        end else begin : g_inclusive
            assign over = (level >= thr);
        end
    endgenerate

    // Register the gated comparison as the status flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else begin
            hit <= en && over;
        end
    end

    // The flag is only ever raised by an enabled trigger
    assert_hit_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(en));

endmodule

// File: rtl/rx_irq_coalescer.sv
// Module rx_irq_coalescer
// Purpose: counts queued frames, bytes and wait time, runs three separately
//          enabled threshold triggers, and merges them into one sticky,
//          write-1-to-clear receive-interrupt status bit and a gated pin.
// Assumes: the queue logic reports each store and release once, together
//          with its length. us_tick is a one-cycle pulse. irq_clr is a
//          one-cycle strobe from the register decode.
module rx_irq_coalescer
    import rx_irq_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int BYTE_W  = 16,
    parameter int TIME_W  = 16,
    parameter int LEN_W   = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    input  logic [LEN_W-1:0]   enq_len,
    input  logic               deq_valid,
    input  logic [LEN_W-1:0]   deq_len,
    input  logic               us_tick,
    input  logic [FRAME_W-1:0] frame_thr,
    input  logic [BYTE_W-1:0]  byte_thr,
    input  logic [TIME_W-1:0]  time_thr,
    input  logic               frame_en,
    input  logic               byte_en,
    input  logic               time_en,
    input  logic               irq_en,
    input  logic               irq_clr,
    output logic [FRAME_W-1:0] frame_level,
    output logic [BYTE_W-1:0]  byte_level,
    output logic [TIME_W-1:0]  wait_level,
    output logic               frame_hit,
    output logic               byte_hit,
    output logic               time_hit,
    output logic               irq_stat,
    output logic               irq_out
);

    logic                busy_nxt;
    logic [NUM_TRIG-1:0] hits;

    // Frame and byte counts
    rx_queue_tally #(
        .FRAME_W (FRAME_W),
        .BYTE_W  (BYTE_W),
        .LEN_W   (LEN_W)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .enq_len   (enq_len),
        .deq_valid (deq_valid),
        .deq_len   (deq_len),
        .frame_cnt (frame_level),
        .byte_cnt  (byte_level),
        .busy_nxt  (busy_nxt)
    );

    // Time the queue has been non-empty
    rx_wait_timer #(
        .TIME_W (TIME_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .busy_now (frame_level != '0),
        .busy_nxt (busy_nxt),
        .wait_cnt (wait_level)
    );

    // Frame trigger: fires on reaching the limit
    rx_thresh_cmp #(
        .W      (FRAME_W),
        .STRICT (1'b0)
    ) u_cmp_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (frame_en),
        .level (frame_level),
        .thr   (frame_thr),
        .hit   (frame_hit)
    );

    // Byte trigger: fires past the limit
    rx_thresh_cmp #(
        .W      (BYTE_W),
        .STRICT (1'b1)
    ) u_cmp_byte (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (byte_en),
        .level (byte_level),
        .thr   (byte_thr),
        .hit   (byte_hit)
    );

    // Wait-time trigger: fires past the limit
    rx_thresh_cmp #(
        .W      (TIME_W),
        .STRICT (1'b1)
    ) u_cmp_time (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (time_en),
        .level (wait_level),
        .thr   (time_thr),
        .hit   (time_hit)
    );

    // Gather the trigger flags into one vector
    always_comb begin
        hits             = '0;
        hits[TRIG_FRAME] = frame_hit;
        hits[TRIG_BYTE]  = byte_hit;
        hits[TRIG_TIME]  = time_hit;
    end

    // Sticky status: a clear request loses to an active trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_stat <= 1'b0;
        end else begin
            irq_stat <= (irq_stat && !irq_clr) || (|hits);
        end
    end

    // Interrupt pin follows the status while enabled
    assign irq_out = irq_stat && irq_en;

    // Any trigger flag raises the status on the next edge
    assert_trigger_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hits) |=> irq_stat);

    // Without a clear, the status holds
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat && !irq_clr) |=> irq_stat);

    // A clear with no active trigger takes effect
    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(|hits)) |=> !irq_stat);

    // The status only drops after a clear request
    assert_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_stat) |-> $past(irq_clr));

endmodule

// File: tb/test_rx_irq_coalescer.sv
// Bench for rx_irq_coalescer: a table pass over the tallies, then directed
// tests of each trigger, the clear rule, gating and saturation.
module test_rx_irq_coalescer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [10:0] enq_len = '0;
    logic        deq_valid = 1'b0;
    logic [10:0] deq_len = '0;
    logic        us_tick = 1'b0;
    logic [7:0]  frame_thr = '0;
    logic [15:0] byte_thr = '0;
    logic [15:0] time_thr = '0;
    logic        frame_en = 1'b0;
    logic        byte_en = 1'b0;
    logic        time_en = 1'b0;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic [7:0]  frame_level;
    logic [15:0] byte_level;
    logic [15:0] wait_level;
    logic        frame_hit, byte_hit, time_hit, irq_stat, irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_irq_coalescer i_rx_irq_coalescer (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_len(enq_len),
        .deq_valid(deq_valid), .deq_len(deq_len),
        .us_tick(us_tick),
        .frame_thr(frame_thr), .byte_thr(byte_thr), .time_thr(time_thr),
        .frame_en(frame_en), .byte_en(byte_en), .time_en(time_en),
        .irq_en(irq_en), .irq_clr(irq_clr),
        .frame_level(frame_level), .byte_level(byte_level), .wait_level(wait_level),
        .frame_hit(frame_hit), .byte_hit(byte_hit), .time_hit(time_hit),
        .irq_stat(irq_stat), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        enq;
        logic [10:0] elen;
        logic        deq;
        logic [10:0] dlen;
        logic [7:0]  exp_frames;
        logic [15:0] exp_bytes;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 11'd64,   1'b0, 11'd0,    8'd1, 16'd64},
        '{1'b1, 11'd1500, 1'b0, 11'd0,    8'd2, 16'd1564},
        '{1'b1, 11'd100,  1'b1, 11'd64,   8'd2, 16'd1600},
        '{1'b0, 11'd0,    1'b1, 11'd1500, 8'd1, 16'd100},
        '{1'b0, 11'd0,    1'b1, 11'd200,  8'd0, 16'd0},
        '{1'b0, 11'd0,    1'b1, 11'd10,   8'd0, 16'd0},
        '{1'b1, 11'd2000, 1'b0, 11'd0,    8'd1, 16'd2000},
        '{1'b1, 11'd60,   1'b1, 11'd2000, 8'd1, 16'd60},
        '{1'b0, 11'd0,    1'b1, 11'd60,   8'd0, 16'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one event for one cycle; returns at the negedge after the edge
    task automatic push(input logic e, input logic [10:0] el, input logic d, input logic [10:0] dl);
        @(negedge clk);
        enq_valid = e; enq_len = el; deq_valid = d; deq_len = dl;
        @(negedge clk);
        enq_valid = 1'b0; deq_valid = 1'b0; enq_len = '0; deq_len = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulse();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        // R10: reset state
        chk("R10 frame_level", frame_level, 0);
        chk("R10 byte_level", byte_level, 0);
        chk("R10 wait_level", wait_level, 0);
        chk("R10 hits", {frame_hit, byte_hit, time_hit}, 0);
        chk("R10 irq_stat", irq_stat, 0);
        chk("R10 irq_out", irq_out, 0);
        rst_n = 1'b1;
        wait_n(1);

        // R1 R2 table pass; all limits 0 but disabled (R6)
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i].enq, VEC[i].elen, VEC[i].deq, VEC[i].dlen);
            chk("R1 frames", frame_level, VEC[i].exp_frames);
            chk("R2 bytes", byte_level, VEC[i].exp_bytes);
            chk("R6 frame_hit disabled", frame_hit, 0);
        end
        wait_n(2);
        chk("R6 irq_stat stays clear", irq_stat, 0);

        // R3 frame trigger, inclusive
        frame_thr = 8'd3; frame_en = 1'b1;
        push(1'b1, 11'd100, 1'b0, 11'd0);
        push(1'b1, 11'd100, 1'b0, 11'd0);
        wait_n(1);
        chk("R3 below limit", frame_hit, 0);
        push(1'b1, 11'd100, 1'b0, 11'd0);
        wait_n(1);
        chk("R3 at limit", frame_hit, 1);
        chk("R7 not yet", irq_stat, 0);
        wait_n(1);
        chk("R7 set", irq_stat, 1);
        chk("R9 gated off", irq_out, 0);
        irq_en = 1'b1;
        #1;
        chk("R9 gated on", irq_out, 1);
        @(negedge clk);
        clear_pulse();
        chk("R8 clear loses to trigger", irq_stat, 1);
        frame_en = 1'b0;
        wait_n(2);
        chk("R6 frame_hit off", frame_hit, 0);
        chk("R7 sticky", irq_stat, 1);
        clear_pulse();
        chk("R8 cleared", irq_stat, 0);
        chk("R9 pin low", irq_out, 0);
        push(1'b0, 11'd0, 1'b1, 11'd100);
        push(1'b0, 11'd0, 1'b1, 11'd100);
        push(1'b0, 11'd0, 1'b1, 11'd100);
        chk("R2 drained", byte_level, 0);

        // R4 byte trigger, strict
        byte_thr = 16'd1000; byte_en = 1'b1;
        push(1'b1, 11'd1000, 1'b0, 11'd0);
        wait_n(1);
        chk("R4 equal no hit", byte_hit, 0);
        push(1'b1, 11'd1, 1'b0, 11'd0);
        wait_n(1);
        chk("R4 past limit", byte_hit, 1);
        wait_n(1);
        chk("R9 pin high", irq_out, 1);
        byte_en = 1'b0;
        push(1'b0, 11'd0, 1'b1, 11'd1000);
        push(1'b0, 11'd0, 1'b1, 11'd1);
        wait_n(2);
        clear_pulse();
        chk("R8 cleared after bytes", irq_stat, 0);

        // R5 wait timer and time trigger, strict
        time_thr = 16'd3; time_en = 1'b1;
        tick();
        tick();
        chk("R5 idle timer", wait_level, 0);
        push(1'b1, 11'd50, 1'b0, 11'd0);
        tick(); tick(); tick();
        chk("R5 three ticks", wait_level, 3);
        wait_n(1);
        chk("R5 equal no hit", time_hit, 0);
        tick();
        chk("R5 four ticks", wait_level, 4);
        wait_n(1);
        chk("R5 past limit", time_hit, 1);
        push(1'b0, 11'd0, 1'b1, 11'd50);
        chk("R5 reset on empty", wait_level, 0);
        wait_n(1);
        chk("R5 hit drops", time_hit, 0);
        time_en = 1'b0;
        wait_n(1);
        clear_pulse();
        chk("R8 cleared after time", irq_stat, 0);

        // R1 saturation at 255 and return to zero
        for (int k = 0; k < 260; k++) push(1'b1, 11'd0, 1'b0, 11'd0);
        chk("R1 saturates", frame_level, 255);
        for (int k = 0; k < 255; k++) push(1'b0, 11'd0, 1'b1, 11'd0);
        chk("R1 back to zero", frame_level, 0);
        chk("R6 no irq while disabled", irq_stat, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule